// File: doc/BRIEF.md
# Windowed Input-High Accumulator

This block measures how long an input stays high. In every clock cycle it adds one when input A is high. In subtract mode it also takes one away when input B is high. The measurement runs over a window of a programmable number of clock cycles that repeats without pause. When a window closes, the running total moves to the result port and the total starts again from zero. The block then gives a one-cycle completion pulse and sets a sticky ready flag. The flag stays set until the reader pulses a read strobe.

The window timer runs on its own, apart from the input signal. Dropping the arm level empties the running total but does not touch the timer. Writing a new window length does not restart the current window either. The new length is held back and used from the next window boundary. A window length of zero selects continuous mode. In continuous mode the total is never cleared by a timer, and the result follows the live count in every cycle.

Top module: `win_high_acc`

## Requirements
- R1: After a synchronous reset, `result` is 0, `done_pulse` and `ready` are 0, and the block is in continuous mode (window length 0).
- R2: With `sub_mode`=0, `arm`=1 and a window length of N>0, the `result` latched at a boundary equals the number of cycles in the closed window of N cycles in which `in_a` was high.
- R3: With `sub_mode`=1, a cycle with only `in_a` high adds one and a cycle with only `in_b` high subtracts one. A cycle with both high, or with both low, leaves the total unchanged.
- R4: In the last cycle of a window, the clock edge loads `result` with the total including that cycle. The same edge restarts the total at zero and raises `done_pulse` for exactly the following cycle. The next window begins in the next cycle.
- R5: `ready` is set by every window boundary and holds until a cycle with `rd_stb` high and no boundary clears it. A boundary and a read strobe in the same cycle leave it set.
- R6: While `arm` is 0 the total is held at zero and nothing is counted. The window timer keeps running, so the boundaries keep their phase.
- R7: A write of `win_data` with `win_wr` high while a window is running neither restarts nor shortens that window. The last value written is used from the next boundary onward.
- R8: With window length 0, `result` follows the running total one edge later in every cycle, and there are no boundaries. A nonzero write in this mode starts the first window at once, counting from zero from the next cycle.
- R9: The total saturates at 2^ACC_W-1 and does not go below 0. It never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Count enable; low clears the running total |
| in_a | input | 1 | Input counted upward while high |
| in_b | input | 1 | Input counted downward while high in subtract mode |
| sub_mode | input | 1 | 0: count A only; 1: A up, B down |
| win_wr | input | 1 | Write strobe for the window length |
| win_data | input | WIN_W | Window length in clock cycles, 0 for continuous |
| rd_stb | input | 1 | Read strobe that clears `ready` |
| result | output | ACC_W | Latched (or live) count |
| done_pulse | output | 1 | One-cycle pulse after each window boundary |
| ready | output | 1 | Sticky flag: new result not yet read |

## Verification
The assertions assume that the inputs are already synchronous to `clk` and change only between edges. They also assume that `win_data` is stable in any cycle in which `win_wr` is high. The bench drives every input on the falling edge and holds it through the next rising edge, so it stays within these assumptions. It runs with a narrow total so that saturation can be reached. It also writes window lengths of 1, short lengths and 0, so that back-to-back boundaries and the change between continuous and windowed mode are both covered.

// File: rtl/win_high_acc.sv
module win_high_acc #(
  parameter int ACC_W = 32,
  parameter int WIN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             sub_mode,
  input  logic             win_wr,
  input  logic [WIN_W-1:0] win_data,
  input  logic             rd_stb,
  output logic [ACC_W-1:0] result,
  output logic             done_pulse,
  output logic             ready
);
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

  logic [WIN_W-1:0] win_len, win_pend, tmr;
  logic [ACC_W-1:0] acc, nxt;

  wire periodic = win_len != '0;
  wire expiry   = periodic && (tmr == win_len - 1'b1);
  wire up       = in_a && !(sub_mode && in_b);
  wire dn       = sub_mode && in_b && !in_a;
  wire start    = !periodic && win_wr && (win_data != '0);
  wire [WIN_W-1:0] pend_eff = win_wr ? win_data : win_pend;

  always_comb begin
    if (!arm)                        nxt = '0;
    else if (up && acc != ACC_MAX)   nxt = acc + 1'b1;
    else if (dn && acc != '0)        nxt = acc - 1'b1;
    else                             nxt = acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_len    <= '0;
      win_pend   <= '0;
      tmr        <= '0;
      acc        <= '0;
      result     <= '0;
      done_pulse <= 1'b0;
      ready      <= 1'b0;
    end else begin
      win_pend   <= pend_eff;
      done_pulse <= expiry;
      if (expiry)      ready <= 1'b1;
      else if (rd_stb) ready <= 1'b0;
      if (!periodic) begin
        result <= nxt;
        if (start) begin
          win_len <= win_data;
          tmr     <= '0;
          acc     <= '0;
        end else begin
          acc <= nxt;
        end
      end else if (expiry) begin
        result  <= nxt;
        acc     <= '0;
        tmr     <= '0;
        win_len <= pend_eff;
      end else begin
        acc <= nxt;
        tmr <= tmr + 1'b1;
      end
    end
  end

  // R4
  boundary_chk: assert property (@(posedge clk) disable iff (rst)
    expiry |=> (done_pulse && acc == '0));
  // R5
  ready_set_chk: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> ready);
  // R5
  ready_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !expiry) |=> !ready);
  // R6
  disarm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !arm |=> (acc == '0));
  // R7
  len_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (periodic && !expiry) |=> (win_len == $past(win_len)));
  // R8
  no_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !periodic |=> !done_pulse);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_MAX && arm && up && !start) |=> (acc == ACC_MAX || done_pulse));
  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (acc == '0 && arm && dn && !expiry && !start) |=> (acc == '0));
endmodule

// File: tb/tb_win_high_acc.sv
module tb_win_high_acc;
  localparam int AW = 8;
  localparam int WW = 16;
  localparam int MAXV = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst, arm, in_a, in_b, sub_mode, win_wr, rd_stb;
  logic [WW-1:0] win_data;
  logic [AW-1:0] result;
  logic done_pulse, ready;

  int tests = 0, fails = 0;
  string phase = "R1";

  int m_len, m_pend, m_cnt, m_acc, m_res, m_done, m_ready;

  always #5 clk = ~clk;

  win_high_acc #(.ACC_W(AW), .WIN_W(WW)) dut (
    .clk(clk), .rst(rst), .arm(arm), .in_a(in_a), .in_b(in_b),
    .sub_mode(sub_mode), .win_wr(win_wr), .win_data(win_data),
    .rd_stb(rd_stb), .result(result), .done_pulse(done_pulse), .ready(ready));

  function automatic int stepv(int v);
    int r;
    r = v;
    if (!arm) r = 0;
    else if (in_a && !(sub_mode && in_b)) begin if (r < MAXV) r++; end
    else if (sub_mode && in_b && !in_a) begin if (r > 0) r--; end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_len = 0; m_pend = 0; m_cnt = 0; m_acc = 0; m_res = 0; m_done = 0; m_ready = 0;
    end else begin
      int nx, ex;
      nx = stepv(m_acc);
      ex = (m_len != 0 && m_cnt == m_len - 1) ? 1 : 0;
      m_done = ex;
      if (win_wr) m_pend = int'(win_data);
      if (m_len == 0) begin
        m_res = nx;
        if (win_wr && win_data != 0) begin
          m_len = int'(win_data); m_cnt = 0; m_acc = 0;
        end else m_acc = nx;
      end else if (ex != 0) begin
        m_res = nx; m_acc = 0; m_cnt = 0; m_len = m_pend;
      end else begin
        m_acc = nx; m_cnt++;
      end
      if (ex != 0) m_ready = 1;
      else if (rd_stb) m_ready = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    chk({phase, " result"}, int'(result), m_res);
    chk({phase, " done_pulse"}, int'(done_pulse), m_done);
    chk({phase, " ready"}, int'(ready), m_ready);
    win_wr = 1'b0;
    rd_stb = 1'b0;
  endtask

  task automatic wr_len(int v);
    win_wr = 1'b1;
    win_data = WW'(v);
    cyc();
  endtask

  task automatic rand_run(int n, bit use_b);
    for (int i = 0; i < n; i++) begin
      in_a = 1'($urandom);
      in_b = use_b ? 1'($urandom) : 1'b0;
      rd_stb = ($urandom % 7) == 0;
      cyc();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int gap;
    rst = 1; arm = 0; in_a = 0; in_b = 0; sub_mode = 0;
    win_wr = 0; win_data = '0; rd_stb = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 result", int'(result), 0);
    chk("R1 done_pulse", int'(done_pulse), 0);
    chk("R1 ready", int'(ready), 0);

    // R8 continuous mode tracks live count
    phase = "R8";
    arm = 1;
    for (int i = 0; i < 6; i++) begin in_a = (i % 2) == 0; cyc(); end
    in_a = 0;
    cyc();
    chk("R8 live count", int'(result), 3);

    // R2 first window of 10, A high for the first 4 cycles
    phase = "R2";
    wr_len(10);
    in_a = 1;
    repeat (4) cyc();
    in_a = 0;
    while (!done_pulse) cyc();
    chk("R2 window count", int'(result), 4);
    chk("R4 pulse width", int'(done_pulse), 1);
    cyc();
    chk("R4 pulse ends", int'(done_pulse), 0);
    rand_run(40, 0);

    // R5 read strobe handling
    phase = "R5";
    rd_stb = 1; cyc();
    chk("R5 cleared", int'(ready), 0);
    rand_run(30, 0);

    // R3 subtract mode
    phase = "R3";
    sub_mode = 1;
    rand_run(60, 1);
    in_a = 1; in_b = 1; repeat (12) cyc();

    // R6 disarm keeps timer phase
    phase = "R6";
    while (!done_pulse) cyc();
    arm = 0; in_a = 1; in_b = 0;
    for (int i = 0; i < 10; i++) begin
      cyc();
      chk("R6 period kept", int'(done_pulse), i == 9 ? 1 : 0);
    end
    chk("R6 zero result", int'(result), 0);
    arm = 1;
    rand_run(20, 1);

    // R7 writes mid-window do not re-phase
    phase = "R7";
    sub_mode = 0;
    while (!done_pulse) cyc();
    repeat (3) cyc();
    wr_len(1);
    wr_len(7);
    gap = 0;
    do begin cyc(); gap++; end while (!done_pulse);
    chk("R7 old window kept", gap, 5);
    gap = 0;
    do begin cyc(); gap++; end while (!done_pulse);
    chk("R7 new window", gap, 7);
    wr_len(1);
    rand_run(20, 0);
    wr_len(3);
    rand_run(20, 1);

    // R9 saturation and floor in continuous mode
    phase = "R9";
    wr_len(0);
    repeat (4) cyc();
    in_a = 1; in_b = 0;
    repeat (300) cyc();
    chk("R9 saturate", int'(result), MAXV);
    sub_mode = 1; in_a = 0; in_b = 1;
    repeat (300) cyc();
    chk("R9 floor", int'(result), 0);

    phase = "R2";
    sub_mode = 0;
    wr_len(25);
    rand_run(200, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule